// File: doc/BRIEF.md
# Paired-Zero Level Decoder

This block sits behind a bank of sixteen time-domain comparators. Each comparator drives its output low when its reference pulse overlaps the input pulse. Once per conversion period, a capture strobe latches the comparator word into a register, before the comparators are precharged for the next period. The block then turns that word into a 5-bit quantization level.

The input pulse is slightly wider than a reference pulse, so a legal word carries either one zero or two zeros at adjacent positions. A lone zero maps to an odd level and an adjacent pair maps to the even level just below it. This gives 32 levels from 16 reference positions. A word with no zero at all is level 0. Every other pattern is reported as invalid, and the last good level is kept on the output.

Top module: `paired_zero_decoder`

## Requirements
- R1: When capture_i is sampled high at rising edge N, the word on raw_i at that edge is decoded and the result appears on the outputs after edge N+1. Changes on raw_i at any other time have no effect on the outputs.
- R2: A word whose only zero is at bit k (0..15) decodes to code_o = 2k+1. Examples: bit 0 gives 1, bit 1 gives 3, bit 5 gives 11, bit 15 gives 31.
- R3: A word whose only zeros are at bits k and k-1 (k in 1..15) decodes to code_o = 2k. Examples: bits 1,0 give 2, bits 5,4 give 10, bits 15,14 give 30.
- R4: The all-ones word 16'hFFFF is a legal pattern and decodes to code_o = 0.
- R5: Any other word (three or more zeros, two zeros that are not adjacent, all zeros) raises invalid_o, keeps valid_o low and leaves code_o at its previous value.
- R6: For each capture, exactly one of valid_o (legal word) or invalid_o (illegal word) is high, for exactly one cycle. Both are low in every cycle that does not follow a capture.
- R7: While rst_ni is low, code_o is 0 and valid_o and invalid_o are 0.
- R8: Captures on consecutive cycles are each decoded, and their results appear on consecutive cycles in capture order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 16 | Comparator word, bit low means overlap |
| capture_i | input | 1 | Latch raw_i at this edge |
| code_o | output | 5 | Decoded quantization level |
| valid_o | output | 1 | One-cycle pulse: legal word decoded |
| invalid_o | output | 1 | One-cycle pulse: illegal word seen |

## Verification
Each result is due one edge after the capture edge. The capture register loads at edge N and the output register loads at edge N+1. The bench raises the strobe at a falling edge and lets two rising edges pass. It then reads code_o, valid_o and invalid_o at the following falling edge, and reads them again one falling edge later to confirm that the pulse has ended. After each capture edge the bench scrambles raw_i, so a design that decodes the live input rather than the captured word shows a wrong level. For back-to-back captures, the bench reads one result per falling edge, in capture order.

// File: rtl/pzl_pkg.sv
`timescale 1ns/1ps
package pzl_pkg;
  function automatic int code_width(input int n_ref);
    return $clog2(n_ref) + 1;
  endfunction
endpackage

// File: rtl/pzl_capture.sv
`timescale 1ns/1ps
module pzl_capture #(
  parameter int N_REF = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REF-1:0] raw_i,
  input  logic             capture_i,
  output logic [N_REF-1:0] word_o,
  output logic             pend_o
);
  logic [N_REF-1:0] word_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '1;
      pend_q <= 1'b0;
    end else begin
      if (capture_i) word_q <= raw_i;
      pend_q <= capture_i;
    end
  end

  assign word_o = word_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pzl_decode.sv
`timescale 1ns/1ps
module pzl_decode #(
  parameter int N_REF  = 16,
  parameter int CODE_W = pzl_pkg::code_width(N_REF)
) (
  input  logic [N_REF-1:0]  word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              legal_o
);
  logic [N_REF-1:0] zeros;
  logic [N_REF-1:0] lone_hit;
  logic [N_REF-1:0] pair_hit;

  assign zeros = ~word_i;

  // one comparator per position: lone zero, and pair ending at this position
  for (genvar k = 0; k < N_REF; k++) begin : g_pos
    assign lone_hit[k] = (zeros == (N_REF'(1) << k));
    if (k == 0) begin : g_nopair
      assign pair_hit[k] = 1'b0;
    end else begin : g_pair
      assign pair_hit[k] = (zeros == (N_REF'(3) << (k - 1)));
    end
  end

  always_comb begin
    code_o  = '0;
    legal_o = (zeros == '0);
    for (int k = 0; k < N_REF; k++) begin
      if (lone_hit[k]) begin
        code_o  = CODE_W'(2 * k + 1);
        legal_o = 1'b1;
      end
      if (pair_hit[k]) begin
        code_o  = CODE_W'(2 * k);
        legal_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pzl_out_stage.sv
`timescale 1ns/1ps
module pzl_out_stage #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              legal_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              invalid_o
);
  logic [CODE_W-1:0] code_q;
  logic              valid_q;
  logic              inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      valid_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      valid_q <= pend_i & legal_i;
      inv_q   <= pend_i & ~legal_i;
      if (pend_i && legal_i) code_q <= code_i;
    end
  end

  assign code_o    = code_q;
  assign valid_o   = valid_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/paired_zero_decoder.sv
`timescale 1ns/1ps
module paired_zero_decoder #(
  parameter int N_REF  = 16,
  localparam int CODE_W = pzl_pkg::code_width(N_REF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REF-1:0]  raw_i,
  input  logic              capture_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              invalid_o
);
  logic [N_REF-1:0]  cap_word;
  logic              cap_pend;
  logic [CODE_W-1:0] dec_code;
  logic              dec_legal;

  pzl_capture #(.N_REF(N_REF)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw_i),
    .capture_i (capture_i),
    .word_o    (cap_word),
    .pend_o    (cap_pend)
  );

  pzl_decode #(.N_REF(N_REF), .CODE_W(CODE_W)) u_decode (
    .word_i  (cap_word),
    .code_o  (dec_code),
    .legal_o (dec_legal)
  );

  pzl_out_stage #(.CODE_W(CODE_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (cap_pend),
    .legal_i   (dec_legal),
    .code_i    (dec_code),
    .code_o    (code_o),
    .valid_o   (valid_o),
    .invalid_o (invalid_o)
  );

  AST_RESULT_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || invalid_o) |-> $past(capture_i, 2)); // R1
  AST_LONE_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_legal && $countones(~cap_word) == 1) |-> dec_code[0]); // R2
  AST_PAIR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_legal && $countones(~cap_word) == 2) |-> !dec_code[0]); // R3
  AST_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cap_word) |-> (dec_legal && dec_code == '0)); // R4
  AST_HOLD_ON_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> $stable(code_o)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, invalid_o})); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o)); // R6
  AST_WIDE_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~cap_word) > 2) |-> !dec_legal); // R5
endmodule

// File: tb/paired_zero_decoder_tb_top.sv
`timescale 1ns/1ps
module paired_zero_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] raw_i = 16'hFFFF;
  logic        capture_i = 1'b0;
  logic [4:0]  code_o;
  logic        valid_o;
  logic        invalid_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] last_code = 5'd0;

  always #2 clk_i = ~clk_i;

  paired_zero_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_i), .capture_i(capture_i),
    .code_o(code_o), .valid_o(valid_o), .invalid_o(invalid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model from R2..R5: returns legal flag and level
  function automatic bit exp_legal(input logic [15:0] w, output logic [4:0] lvl);
    logic [15:0] z = ~w;
    lvl = 5'd0;
    if (z == 16'h0) return 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (z == (16'h1 << k)) begin lvl = 5'(2 * k + 1); return 1'b1; end
      if (k > 0 && z == (16'h3 << (k - 1))) begin lvl = 5'(2 * k); return 1'b1; end
    end
    return 1'b0;
  endfunction

  task automatic convert(input logic [15:0] w, input string req);
    logic [4:0] lvl;
    bit ok;
    ok = exp_legal(w, lvl);
    @(negedge clk_i); raw_i = w; capture_i = 1'b1;
    @(negedge clk_i); capture_i = 1'b0; raw_i = ~w ^ 16'h5A3C; // R1 scramble after capture
    @(negedge clk_i);
    if (ok) last_code = lvl;
    chk(req, code_o, last_code);
    chk(req, valid_o, ok);
    chk(req, invalid_o, !ok);
    @(negedge clk_i);
    chk("R6", {valid_o, invalid_o}, 0);
    chk("R6", code_o, last_code);
  endtask

  task automatic t_reset();
    #1;
    chk("R7", code_o, 0); chk("R7", valid_o, 0); chk("R7", invalid_o, 0);
  endtask

  task automatic t_lone();
    for (int k = 0; k < 16; k++) convert(~(16'h1 << k), "R2");
  endtask

  task automatic t_pair();
    for (int k = 1; k < 16; k++) convert(~(16'h3 << (k - 1)), "R3");
  endtask

  task automatic t_all_ones();
    convert(~16'h0020, "R2");
    convert(16'hFFFF, "R4");
  endtask

  task automatic t_invalid();
    convert(~16'h0020, "R2");
    convert(~16'h0070, "R5");
    convert(~16'h0101, "R5");
    convert(16'h0000, "R5");
    convert(~16'h8001, "R5");
  endtask

  task automatic t_no_strobe();
    convert(~16'h0400, "R2");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); raw_i = 16'(i * 16'h1111);
      @(negedge clk_i);
      chk("R1", code_o, 21); chk("R1", {valid_o, invalid_o}, 0);
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i); raw_i = ~16'h0004; capture_i = 1'b1;   // level 5
    @(negedge clk_i); raw_i = ~16'h6000;                      // level 28
    @(negedge clk_i); raw_i = ~16'h0090;                      // illegal
    chk("R8", code_o, 5);  chk("R8", valid_o, 1);
    @(negedge clk_i); capture_i = 1'b0; raw_i = 16'hFFFF;
    chk("R8", code_o, 28); chk("R8", valid_o, 1);
    @(negedge clk_i);
    chk("R8", code_o, 28); chk("R8", invalid_o, 1);
    @(negedge clk_i);
    chk("R8", {valid_o, invalid_o}, 0);
    last_code = 5'd28;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_lone();
    t_pair();
    t_all_ones();
    t_invalid();
    t_no_strobe();
    t_back_to_back();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule